// File: doc/BRIEF.md
# Per-Core Interrupt Priority Arbiter with Nested Completion

This block is the core-facing half of an interrupt controller, instantiated once per processor core. It holds the pending bit of every interrupt ID for its core and continuously scans the enabled, pending IDs for the one with the best priority. That winner is filtered through a programmable priority mask and then compared with the priority of the interrupt the core is already servicing. The result drives the core's interrupt request line.

Software claims the winner with an acknowledge read. A claimed ID becomes the running interrupt and keeps a link to the one it preempted. Software retires an interrupt with an end-of-interrupt write. Retiring the running ID restores its predecessor. Retiring an ID deeper in the nest removes it from the chain and leaves the running ID alone, so completions may arrive out of order. The distributor side supplies enables, priorities, trigger configuration, line levels and set/clear pulses for the pending bits.

Top module: `irq_core_arbiter`

## Requirements
- R1: Among IDs that are enabled and pending, the smallest priority value wins. When priorities are equal, the smallest ID wins.
- R2: ID 1023 means "no interrupt". While nothing runs, `run_id` is 1023 and `run_prio` is 0x100, which loses to every 8-bit priority.
- R3: `hi_pend` shows the winner only when its priority is less than or equal to the priority mask; otherwise it shows 1023. `irq_req` is high only when `hi_pend` is valid and its priority is strictly smaller than `run_prio`.
- R4: When `glb_en` is low or the core enable is off, `irq_req` is low and `hi_pend` is 1023.
- R5: An acknowledge read returns 1023 and changes nothing when no ID is shown in `hi_pend` or its priority is not strictly better than `run_prio`.
- R6: A successful acknowledge returns the ID and clears its pending bit. It records the previous running ID as the new ID's link and makes the new ID running at its priority. When the ID's `irq_bcast` bit is set, it also pulses `clr_all_vld` with the ID on `clr_all_id` in the same cycle, so the other cores clear it too.
- R7: End-of-interrupt uses bits [9:0] of `eoi_data`. The write is ignored when the ID is at or above the implemented count, or when nothing is running. An acknowledge in the same cycle takes precedence.
- R8: At end of interrupt, if the ID is level-triggered (`irq_edge` bit 0), enabled, its line is high and it targets this core, its pending bit is set again.
- R9: Completing the running ID makes its linked predecessor running, with that predecessor's priority, or the idle values when the link is 1023.
- R10: Completing an ID that is nested below the running one unlinks it from the chain without changing `run_id`. A later completion of the running ID then skips it.
- R11: After reset the priority mask is 0xF0, the core enable is off, all pending bits are clear, and `run_id` and `hi_pend` are 1023.
- R12: A priority mask write keeps only bits [7:0] of `pmask_wdata`. A core enable write keeps only bit 0 of `cen_wdata`.
- R13: A pulse on `irq_set_pend` sets that ID's pending bit and a pulse on `irq_clr_pend` clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| glb_en | input | 1 | Controller-wide enable |
| cen_wr | input | 1 | Core enable write strobe |
| cen_wdata | input | 32 | Core enable write data (bit 0 used) |
| pmask_wr | input | 1 | Priority mask write strobe |
| pmask_wdata | input | 32 | Priority mask write data (bits [7:0] used) |
| irq_en | input | N_IRQ | Per-ID enable for this core |
| irq_set_pend | input | N_IRQ | Per-ID set-pending pulses |
| irq_clr_pend | input | N_IRQ | Per-ID clear-pending pulses |
| irq_level | input | N_IRQ | Current line level per ID |
| irq_edge | input | N_IRQ | 1 = edge-triggered, 0 = level-triggered |
| irq_tgt | input | N_IRQ | ID is targeted at this core |
| irq_bcast | input | N_IRQ | Claiming the ID clears it on all cores |
| irq_prio | input | N_IRQ*PRIO_W | Packed priorities, ID i at [i*PRIO_W +: PRIO_W] |
| ack_rd | input | 1 | Acknowledge read strobe |
| ack_data | output | ID_W | Acknowledge read data (same cycle) |
| clr_all_vld | output | 1 | Broadcast pending-clear pulse |
| clr_all_id | output | ID_W | ID for the broadcast clear |
| eoi_wr | input | 1 | End-of-interrupt write strobe |
| eoi_data | input | 32 | End-of-interrupt write data |
| irq_req | output | 1 | Interrupt request to the core |
| hi_pend | output | ID_W | Highest pending ID passing the mask, or 1023 |
| run_id | output | ID_W | Running ID, or 1023 |
| run_prio | output | PRIO_W+1 | Running priority, 0x100 when idle |

## Verification
The hardest state to reach is a nest three deep, where an end-of-interrupt names the middle entry. Only a correct splice makes the next completion of the running ID skip past it. The bench gets there by raising strictly better priorities one after another, claiming each one so the chain grows. It then completes the middle entry and checks that `run_id` is unchanged. The next completion carries a stray bit above bit 9, and the bench checks that this completion lands on the oldest entry with its priority.

// File: rtl/irq_core_arbiter.sv
`timescale 1ns/1ps
module irq_core_arbiter #(
  parameter int N_IRQ = 32,
  parameter int PRIO_W = 8,
  parameter int ID_W = 10,
  parameter logic [PRIO_W-1:0] MASK_RESET = 8'hF0
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    glb_en,
  input  logic                    cen_wr,
  input  logic [31:0]             cen_wdata,
  input  logic                    pmask_wr,
  input  logic [31:0]             pmask_wdata,
  input  logic [N_IRQ-1:0]        irq_en,
  input  logic [N_IRQ-1:0]        irq_set_pend,
  input  logic [N_IRQ-1:0]        irq_clr_pend,
  input  logic [N_IRQ-1:0]        irq_level,
  input  logic [N_IRQ-1:0]        irq_edge,
  input  logic [N_IRQ-1:0]        irq_tgt,
  input  logic [N_IRQ-1:0]        irq_bcast,
  input  logic [N_IRQ*PRIO_W-1:0] irq_prio,
  input  logic                    ack_rd,
  output logic [ID_W-1:0]         ack_data,
  output logic                    clr_all_vld,
  output logic [ID_W-1:0]         clr_all_id,
  input  logic                    eoi_wr,
  input  logic [31:0]             eoi_data,
  output logic                    irq_req,
  output logic [ID_W-1:0]         hi_pend,
  output logic [ID_W-1:0]         run_id,
  output logic [PRIO_W:0]         run_prio
);

  localparam int IDX_W = (N_IRQ > 1) ? $clog2(N_IRQ) : 1;
  localparam logic [ID_W-1:0] IDLE_ID = '1;
  localparam logic [ID_W-1:0] N_ID = ID_W'(N_IRQ);
  localparam logic [PRIO_W:0] PRIO_IDLE = {1'b1, {PRIO_W{1'b0}}};

  logic [N_IRQ-1:0]  pend_q, pend_d;
  logic [ID_W-1:0]   link_q [N_IRQ];
  logic [ID_W-1:0]   run_id_q;
  logic [PRIO_W:0]   run_prio_q;
  logic [PRIO_W-1:0] pmask_q;
  logic              cen_q;

  logic [PRIO_W:0]   best_prio;
  logic [IDX_W-1:0]  best_idx;
  logic              live;

  always_comb begin
    best_prio = PRIO_IDLE;
    best_idx  = '0;
    for (int i = 0; i < N_IRQ; i++) begin
      if (irq_en[i] && pend_q[i] && {1'b0, irq_prio[i*PRIO_W +: PRIO_W]} < best_prio) begin
        best_prio = {1'b0, irq_prio[i*PRIO_W +: PRIO_W]};
        best_idx  = IDX_W'(i);
      end
    end
  end

  assign live     = glb_en && cen_q && (best_prio <= {1'b0, pmask_q});
  assign hi_pend  = live ? ID_W'(best_idx) : IDLE_ID;
  assign irq_req  = live && (best_prio < run_prio_q);
  assign run_id   = run_id_q;
  assign run_prio = run_prio_q;

  logic ack_ok;
  assign ack_ok      = ack_rd && irq_req;
  assign ack_data    = ack_ok ? hi_pend : IDLE_ID;
  assign clr_all_vld = ack_ok && irq_bcast[best_idx];
  assign clr_all_id  = clr_all_vld ? hi_pend : IDLE_ID;

  logic [ID_W-1:0]  eoi_id;
  logic [IDX_W-1:0] eoi_idx, run_idx;
  logic             eoi_ok, eoi_cur, repend;
  assign eoi_id  = eoi_data[ID_W-1:0];
  assign eoi_idx = eoi_id[IDX_W-1:0];
  assign run_idx = run_id_q[IDX_W-1:0];
  assign eoi_ok  = eoi_wr && !ack_rd && (eoi_id < N_ID) && (run_id_q != IDLE_ID);
  assign eoi_cur = eoi_ok && (eoi_id == run_id_q);
  assign repend  = eoi_ok && !irq_edge[eoi_idx] && irq_en[eoi_idx]
                   && irq_level[eoi_idx] && irq_tgt[eoi_idx];

  logic [ID_W-1:0]  restore_id;
  logic [IDX_W-1:0] restore_idx;
  logic [PRIO_W:0]  restore_prio;
  assign restore_id   = link_q[run_idx];
  assign restore_idx  = restore_id[IDX_W-1:0];
  assign restore_prio = (restore_id == IDLE_ID) ? PRIO_IDLE
                        : {1'b0, irq_prio[int'(restore_idx)*PRIO_W +: PRIO_W]};

  logic             splice_hit, walk_stop;
  logic [IDX_W-1:0] splice_idx, walk_cur;
  logic [ID_W-1:0]  walk_nxt;

  always_comb begin
    splice_hit = 1'b0;
    splice_idx = '0;
    walk_stop  = 1'b0;
    walk_cur   = run_idx;
    walk_nxt   = IDLE_ID;
    for (int k = 0; k < N_IRQ; k++) begin
      if (!walk_stop) begin
        walk_nxt = link_q[walk_cur];
        if (walk_nxt == IDLE_ID || walk_nxt >= N_ID) begin
          walk_stop = 1'b1;
        end else if (walk_nxt == eoi_id) begin
          splice_hit = 1'b1;
          splice_idx = walk_cur;
          walk_stop  = 1'b1;
        end else begin
          walk_cur = walk_nxt[IDX_W-1:0];
        end
      end
    end
  end

  always_comb begin
    pend_d = pend_q & ~irq_clr_pend;
    if (ack_ok) pend_d[best_idx] = 1'b0;
    pend_d = pend_d | irq_set_pend;
    if (repend) pend_d[eoi_idx] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend_q     <= '0;
      run_id_q   <= IDLE_ID;
      run_prio_q <= PRIO_IDLE;
      pmask_q    <= MASK_RESET;
      cen_q      <= 1'b0;
      for (int i = 0; i < N_IRQ; i++) link_q[i] <= IDLE_ID;
    end else begin
      pend_q <= pend_d;
      if (cen_wr)   cen_q   <= cen_wdata[0];
      if (pmask_wr) pmask_q <= pmask_wdata[PRIO_W-1:0];
      if (ack_ok) begin
        link_q[best_idx] <= run_id_q;
        run_id_q         <= hi_pend;
        run_prio_q       <= best_prio;
      end else if (eoi_cur) begin
        run_id_q   <= restore_id;
        run_prio_q <= restore_prio;
      end else if (eoi_ok && splice_hit) begin
        link_q[splice_idx] <= link_q[eoi_idx];
      end
    end
  end

  logic unused_bits;
  assign unused_bits = ^{cen_wdata[31:1], pmask_wdata[31:PRIO_W], eoi_data[31:ID_W]};

  AST_IDLE_PRIO: assert property (@(posedge clk) disable iff (!rst_n)
    run_id_q == IDLE_ID |-> run_prio_q == PRIO_IDLE); // R2
  AST_PEND_UNDER_MASK: assert property (@(posedge clk) disable iff (!rst_n)
    hi_pend != IDLE_ID |-> irq_prio[int'(hi_pend[IDX_W-1:0])*PRIO_W +: PRIO_W] <= pmask_q); // R3
  AST_ENABLES_GATE: assert property (@(posedge clk) disable iff (!rst_n)
    (!glb_en || !cen_q) |-> (!irq_req && hi_pend == IDLE_ID)); // R4
  AST_REFUSED_ACK: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_rd && ack_data == IDLE_ID) |=> $stable(run_id_q) && $stable(run_prio_q)); // R5
  AST_ACK_RUNS: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_data != IDLE_ID) |=> run_id_q == $past(ack_data)); // R6
  AST_EOI_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (eoi_wr && !ack_rd && (eoi_data[ID_W-1:0] >= N_ID || run_id_q == IDLE_ID))
    |=> $stable(run_id_q) && $stable(run_prio_q)); // R7
  AST_NESTED_EOI_KEEPS_RUN: assert property (@(posedge clk) disable iff (!rst_n)
    (eoi_ok && !eoi_cur) |=> $stable(run_id_q)); // R10

endmodule

// File: tb/tb_irq_core_arbiter.sv
`timescale 1ns/1ps
module tb_irq_core_arbiter;
  localparam int N = 32;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic glb_en = 1'b0;
  logic cen_wr = 1'b0;
  logic [31:0] cen_wdata = '0;
  logic pmask_wr = 1'b0;
  logic [31:0] pmask_wdata = '0;
  logic [N-1:0] irq_en = '0, irq_set_pend = '0, irq_clr_pend = '0;
  logic [N-1:0] irq_level = '0, irq_edge = '1, irq_tgt = '1, irq_bcast = '0;
  logic [N*8-1:0] irq_prio = '0;
  logic ack_rd = 1'b0;
  logic [9:0] ack_data, clr_all_id, hi_pend, run_id;
  logic clr_all_vld, irq_req;
  logic eoi_wr = 1'b0;
  logic [31:0] eoi_data = '0;
  logic [8:0] run_prio;

  int checks = 0;
  int fails = 0;
  int ack_got;
  int bc_vld;
  int bc_id;

  always #4 clk = ~clk;

  irq_core_arbiter dut (
    .clk(clk), .rst_n(rst_n), .glb_en(glb_en),
    .cen_wr(cen_wr), .cen_wdata(cen_wdata),
    .pmask_wr(pmask_wr), .pmask_wdata(pmask_wdata),
    .irq_en(irq_en), .irq_set_pend(irq_set_pend), .irq_clr_pend(irq_clr_pend),
    .irq_level(irq_level), .irq_edge(irq_edge), .irq_tgt(irq_tgt),
    .irq_bcast(irq_bcast), .irq_prio(irq_prio),
    .ack_rd(ack_rd), .ack_data(ack_data),
    .clr_all_vld(clr_all_vld), .clr_all_id(clr_all_id),
    .eoi_wr(eoi_wr), .eoi_data(eoi_data),
    .irq_req(irq_req), .hi_pend(hi_pend), .run_id(run_id), .run_prio(run_prio)
  );

  // {enable, pending, mask, expected hi_pend, expected request}; priority of ID i is (i/4)*32
  localparam logic [82:0] VEC [9] = '{
    {32'hFFFF_FFFF, 32'h0000_0000, 8'hF0, 10'd1023, 1'b0},
    {32'hFFFF_FFFF, 32'h0000_0220, 8'hF0, 10'd5,    1'b1},
    {32'hFFFF_FFFF, 32'h0000_0060, 8'hF0, 10'd5,    1'b1},
    {32'hFFFF_FFFF, 32'h4000_0000, 8'hF0, 10'd30,   1'b1},
    {32'hFFFF_FFFF, 32'h4000_0000, 8'hD0, 10'd1023, 1'b0},
    {32'hFFFF_FFFF, 32'h4000_0000, 8'hE0, 10'd30,   1'b1},
    {32'hFFFF_FFFB, 32'h0000_000C, 8'hF0, 10'd3,    1'b1},
    {32'h0000_0000, 32'hFFFF_FFFF, 8'hF0, 10'd1023, 1'b0},
    {32'hFFFF_FFFF, 32'h8002_0000, 8'hF0, 10'd17,   1'b1}
  };

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic set_p(input int id);
    @(negedge clk) irq_set_pend = N'(1) << id;
    @(negedge clk) irq_set_pend = '0;
  endtask

  task automatic clr_all();
    @(negedge clk) irq_clr_pend = '1;
    @(negedge clk) irq_clr_pend = '0;
  endtask

  task automatic wr_mask(input logic [31:0] v);
    @(negedge clk) begin pmask_wr = 1'b1; pmask_wdata = v; end
    @(negedge clk) pmask_wr = 1'b0;
  endtask

  task automatic wr_cen(input logic [31:0] v);
    @(negedge clk) begin cen_wr = 1'b1; cen_wdata = v; end
    @(negedge clk) cen_wr = 1'b0;
  endtask

  task automatic do_ack();
    @(negedge clk) ack_rd = 1'b1;
    #1;
    ack_got = int'(ack_data);
    bc_vld  = int'(clr_all_vld);
    bc_id   = int'(clr_all_id);
    @(negedge clk) ack_rd = 1'b0;
  endtask

  task automatic do_eoi(input logic [31:0] v);
    @(negedge clk) begin eoi_wr = 1'b1; eoi_data = v; end
    @(negedge clk) eoi_wr = 1'b0;
  endtask

  initial begin
    #(8 * 100000);
    fails++;
    checks++;
    $display("FAIL watchdog: actual running expected finished");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    for (int i = 0; i < N; i++) irq_prio[i*8 +: 8] = 8'((i / 4) * 32);
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R11 reset req", int'(irq_req), 0);
    chk("R11 reset hi_pend", int'(hi_pend), 1023);
    chk("R2 reset run_id", int'(run_id), 1023);
    chk("R2 reset run_prio", int'(run_prio), 256);

    glb_en = 1'b1;
    irq_en = '1;
    irq_prio[10*8 +: 8] = 8'hF0;
    set_p(10);
    chk("R11 core enable off after reset", int'(hi_pend), 1023);
    wr_cen(32'h1);
    chk("R11 mask 0xF0 admits equal priority", int'(hi_pend), 10);
    @(negedge clk) irq_prio[10*8 +: 8] = 8'hF1;
    @(negedge clk);
    chk("R11 mask 0xF0 rejects 0xF1", int'(hi_pend), 1023);
    irq_prio[10*8 +: 8] = 8'd64;
    clr_all();
    chk("R13 clear pulse", int'(hi_pend), 1023);

    set_p(0);
    chk("R13 set pulse", int'(hi_pend), 0);
    wr_mask(32'h100);
    chk("R12 mask zero admits priority 0", int'(hi_pend), 0);
    @(negedge clk) irq_prio[7:0] = 8'd1;
    @(negedge clk);
    chk("R12 mask keeps 8 bits", int'(hi_pend), 1023);
    irq_prio[7:0] = 8'd0;
    wr_mask(32'hF0);
    wr_cen(32'h2);
    chk("R12 core enable uses bit 0", int'(hi_pend), 1023);
    wr_cen(32'h1);
    chk("R12 core enable back on", int'(irq_req), 1);
    @(negedge clk) glb_en = 1'b0;
    @(negedge clk);
    chk("R4 global off req", int'(irq_req), 0);
    chk("R4 global off hi_pend", int'(hi_pend), 1023);
    glb_en = 1'b1;
    clr_all();

    for (int v = 0; v < 9; v++) begin
      clr_all();
      @(negedge clk) begin
        irq_en = VEC[v][82:51];
        irq_set_pend = VEC[v][50:19];
        pmask_wr = 1'b1;
        pmask_wdata = {24'd0, VEC[v][18:11]};
      end
      @(negedge clk) begin irq_set_pend = '0; pmask_wr = 1'b0; end
      chk($sformatf("R1/R3 vector %0d hi_pend", v), int'(hi_pend), int'(VEC[v][10:1]));
      chk($sformatf("R3 vector %0d req", v), int'(irq_req), int'(VEC[v][0]));
    end
    irq_en = '1;
    wr_mask(32'hF0);
    clr_all();

    do_ack();
    chk("R5 ack with nothing pending", ack_got, 1023);
    chk("R5 run unchanged", int'(run_id), 1023);

    set_p(8);
    do_ack();
    chk("R6 ack returns id", ack_got, 8);
    chk("R6 running priority", int'(run_prio), 64);
    chk("R6 pending cleared", int'(hi_pend), 1023);
    set_p(4);
    chk("R3 better priority requests", int'(irq_req), 1);
    do_ack();
    chk("R6 nested ack", ack_got, 4);
    set_p(9);
    chk("R3 masked-in but not better shows id", int'(hi_pend), 9);
    chk("R3 not better gives no request", int'(irq_req), 0);
    do_ack();
    chk("R5 ack refused when not better", ack_got, 1023);
    chk("R5 run kept", int'(run_id), 4);
    do_eoi(32'd4);
    chk("R9 restore predecessor", int'(run_id), 8);
    chk("R9 predecessor priority", int'(run_prio), 64);
    chk("R3 equal to running gives no request", int'(irq_req), 0);
    do_eoi(32'd8);
    chk("R9 restore idle", int'(run_id), 1023);
    chk("R9 idle priority", int'(run_prio), 256);
    chk("R3 request after idle", int'(irq_req), 1);
    do_ack();
    do_eoi(32'd9);
    clr_all();

    set_p(12); do_ack();
    set_p(8);  do_ack();
    set_p(4);  do_ack();
    chk("R6 three deep", int'(run_id), 4);
    do_eoi(32'd8);
    chk("R10 nested completion keeps running", int'(run_id), 4);
    do_eoi(32'h3FF);
    chk("R7 spurious id ignored", int'(run_id), 4);
    do_eoi(32'd32);
    chk("R7 id at count ignored", int'(run_id), 4);
    do_eoi(32'h404);
    chk("R10 splice skips completed entry", int'(run_id), 12);
    chk("R7 low 10 bits used", int'(run_prio), 96);
    do_eoi(32'd12);
    chk("R9 chain empties", int'(run_id), 1023);

    @(negedge clk) begin irq_edge[20] = 1'b0; irq_level[20] = 1'b1; end
    do_eoi(32'd20);
    chk("R7 idle completion ignored", int'(hi_pend), 1023);
    set_p(20);
    do_ack();
    chk("R6 level id acked", ack_got, 20);
    chk("R6 level pending cleared", int'(hi_pend), 1023);
    do_eoi(32'd20);
    chk("R8 level line re-pends", int'(hi_pend), 20);
    clr_all();
    @(negedge clk) irq_tgt[20] = 1'b0;
    set_p(20); do_ack(); do_eoi(32'd20);
    chk("R8 untargeted line not re-pended", int'(hi_pend), 1023);
    @(negedge clk) begin irq_tgt[20] = 1'b1; irq_level[21] = 1'b1; end
    set_p(21); do_ack(); do_eoi(32'd21);
    chk("R8 edge line not re-pended", int'(hi_pend), 1023);
    @(negedge clk) begin irq_edge[20] = 1'b1; irq_level = '0; irq_bcast[16] = 1'b1; end

    set_p(16);
    do_ack();
    chk("R6 broadcast pulse", bc_vld, 1);
    chk("R6 broadcast id", bc_id, 16);
    do_eoi(32'd16);
    set_p(17);
    do_ack();
    chk("R6 no broadcast for per-core model", bc_vld, 0);
    do_eoi(32'd17);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule